// File: doc/BRIEF.md
# Operand Readiness Scoreboard with Pipe-Aware Bypass Timing

This block keeps, for every architectural register, a count of how many cycles remain before the register's pending result can be read by a waiting instruction. The issue port carries a destination register, the pipe that produces the result and the operation class. The class sets the latency. Each register entry also records which pipe produced its value. A lookup port takes a source register and the pipe that wants to consume it, and answers one cycle later whether the operand is available.

Two fixed-point pipes each forward their own results back to themselves after one cycle. A result that crosses to the other fixed-point pipe costs one extra cycle. Results from the load/store pipe and the vector/scalar pipe carry no such adjustment. Word and doubleword divides are not pipelined. While one runs, its fixed-point pipe refuses every other issue, and the block reports that pipe as busy.

Top module: `opsb_scoreboard`

## Requirements
- R1: While reset is held and in the first cycle after it, fx_busy is 0 and lk_ready is 1. Every register then reads as ready for any consumer pipe until it is written by an accepted issue.
- R2: Pipe codes are 0 and 1 for the two fixed-point pipes, 2 for load/store and 3 for vector/scalar. Suppose a result of latency L is issued in cycle t by a fixed-point pipe. A lookup from that same pipe is ready from cycle t+L, so a simple op (L=1) can be consumed in the very next cycle.
- R3: A lookup from the other fixed-point pipe is ready only from cycle t+L+1.
- R4: Latency by op class code: 0 simple = 1, 1 multiply = 4, 4 floating-point general = 5, 5 vector floating-point = 6.
- R5: Class 2 (load into a fixed-point register) has latency 2. Class 3 (load into a vector/scalar register) has latency 3.
- R6: Class 6 (word divide) and class 7 (doubleword divide) have latencies 36 and 68. When one is accepted on fixed-point pipe p in cycle t, fx_busy[p] is 1 in cycles t+1 through t+latency-1 and 0 in cycle t+latency.
- R7: Two kinds of issue are dropped and leave every register entry and both busy indications unchanged. The first is an issue on a fixed-point pipe whose fx_busy bit is 1. The second is a divide class issued on pipe 2 or 3.
- R8: An accepted issue to a register replaces its pending entry, whether the new latency is shorter or longer than what was left.
- R9: lk_ready in cycle c+1 answers the lookup presented in cycle c. It uses the state before any issue accepted in cycle c.
- R10: When the producer is pipe 2 or 3, every consumer pipe sees the result from cycle t+L with no adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_dst | input | RW | Destination register of the issue |
| iss_pipe | input | 2 | Producing pipe code |
| iss_class | input | 3 | Operation class code |
| lk_src | input | RW | Source register looked up |
| lk_pipe | input | 2 | Consumer pipe code of the lookup |
| lk_ready | output | 1 | Registered readiness answer for the previous cycle's lookup |
| fx_busy | output | 2 | Per fixed-point pipe, a divide is occupying it |

## Verification
Directed sequences probe one register at a time. A simple result is looked up from the same fixed-point pipe and then from the other one, which separates the self-bypass from the cross-pipe cycle. Each load and long-latency class is then polled every cycle to pin down the exact first ready cycle. Issues are sent to a pipe that is busy with a divide and divides are sent to non-fixed-point pipes, followed by lookups of the targeted registers, to show that the dropped issues leave nothing behind. Overwrites with shorter and longer latencies, and a lookup of the register being written in the same cycle, show replacement and the pre-update view. A long run of random issue and lookup traffic confined to a few hot registers then mixes all classes, pipes and divides against the bench's cycle-stamped model.

// File: rtl/opsb_pkg.sv
package opsb_pkg;

  typedef enum logic [1:0] {
    PIPE_FX0 = 2'd0,
    PIPE_FX1 = 2'd1,
    PIPE_LS  = 2'd2,
    PIPE_VS  = 2'd3
  } pipe_e;

  typedef enum logic [2:0] {
    OP_SIMPLE = 3'd0,
    OP_MUL    = 3'd1,
    OP_LD_FX  = 3'd2,
    OP_LD_VS  = 3'd3,
    OP_FP     = 3'd4,
    OP_VFP    = 3'd5,
    OP_DIVW   = 3'd6,
    OP_DIVD   = 3'd7
  } opcls_e;

  function automatic int max_pair(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // fixed-point pipes have the upper code bit clear
  function automatic logic pipe_is_fx(input logic [1:0] p);
    return !p[1];
  endfunction

endpackage

// File: rtl/opsb_lat_decode.sv
module opsb_lat_decode #(
  parameter int CW        = 7,
  parameter int LAT_SIMPLE = 1,
  parameter int LAT_MUL   = 4,
  parameter int LAT_LD_FX = 2,
  parameter int LAT_LD_VS = 3,
  parameter int LAT_FP    = 5,
  parameter int LAT_VFP   = 6,
  parameter int LAT_DIVW  = 36,
  parameter int LAT_DIVD  = 68
) (
  input  logic [2:0]    cls,
  output logic [CW-1:0] lat,
  output logic          is_div
);
  import opsb_pkg::*;

  always_comb begin
    is_div = 1'b0;
    unique case (opcls_e'(cls))
      OP_SIMPLE: lat = CW'(LAT_SIMPLE);
      OP_MUL:    lat = CW'(LAT_MUL);
      OP_LD_FX:  lat = CW'(LAT_LD_FX);
      OP_LD_VS:  lat = CW'(LAT_LD_VS);
      OP_FP:     lat = CW'(LAT_FP);
      OP_VFP:    lat = CW'(LAT_VFP);
      OP_DIVW: begin lat = CW'(LAT_DIVW); is_div = 1'b1; end
      default: begin lat = CW'(LAT_DIVD); is_div = 1'b1; end
    endcase
  end
endmodule

// File: rtl/opsb_entry.sv
module opsb_entry #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_lat,
  input  logic [1:0]    load_pipe,
  output logic [CW-1:0] cnt,
  output logic [1:0]    src_pipe
);
  // cnt == 1 : same-pipe consumer may read; cnt == 0 : everyone may read
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      src_pipe <= 2'd0;
    end else if (load) begin
      cnt      <= load_lat;
      src_pipe <= load_pipe;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/opsb_unit_busy.sv
module opsb_unit_busy #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          busy
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                 remain <= '0;
    else if (start)          remain <= len - 1'b1;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/opsb_scoreboard.sv
module opsb_scoreboard #(
  parameter int NUM_REGS   = 32,
  parameter int RW         = $clog2(NUM_REGS),
  parameter int LAT_SIMPLE = 1,
  parameter int LAT_MUL    = 4,
  parameter int LAT_LD_FX  = 2,
  parameter int LAT_LD_VS  = 3,
  parameter int LAT_FP     = 5,
  parameter int LAT_VFP    = 6,
  parameter int LAT_DIVW   = 36,
  parameter int LAT_DIVD   = 68
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [RW-1:0] iss_dst,
  input  logic [1:0]    iss_pipe,
  input  logic [2:0]    iss_class,
  input  logic [RW-1:0] lk_src,
  input  logic [1:0]    lk_pipe,
  output logic          lk_ready,
  output logic [1:0]    fx_busy
);
  import opsb_pkg::*;

  localparam int MAX_LAT = max_pair(max_pair(max_pair(LAT_SIMPLE, LAT_MUL),
                                             max_pair(LAT_LD_FX, LAT_LD_VS)),
                                    max_pair(max_pair(LAT_FP, LAT_VFP),
                                             max_pair(LAT_DIVW, LAT_DIVD)));
  localparam int CW = $clog2(MAX_LAT + 1);
  localparam int NUM_FX = 2;

  logic [CW-1:0] iss_lat;
  logic          iss_div;
  logic          iss_fx;
  logic          accept;

  logic [CW-1:0] cnt_arr  [NUM_REGS];
  logic [1:0]    pipe_arr [NUM_REGS];

  opsb_lat_decode #(
    .CW(CW), .LAT_SIMPLE(LAT_SIMPLE), .LAT_MUL(LAT_MUL),
    .LAT_LD_FX(LAT_LD_FX), .LAT_LD_VS(LAT_LD_VS), .LAT_FP(LAT_FP),
    .LAT_VFP(LAT_VFP), .LAT_DIVW(LAT_DIVW), .LAT_DIVD(LAT_DIVD)
  ) u_dec (
    .cls(iss_class), .lat(iss_lat), .is_div(iss_div)
  );

  assign iss_fx = pipe_is_fx(iss_pipe);
  assign accept = iss_valid
               && !(iss_fx && fx_busy[iss_pipe[0]])
               && !(iss_div && !iss_fx);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    opsb_entry #(.CW(CW)) u_ent (
      .clk(clk), .rst(rst),
      .load(accept && (iss_dst == RW'(i))),
      .load_lat(iss_lat), .load_pipe(iss_pipe),
      .cnt(cnt_arr[i]), .src_pipe(pipe_arr[i])
    );
  end

  for (genvar p = 0; p < NUM_FX; p++) begin : g_fx
    opsb_unit_busy #(.CW(CW)) u_busy (
      .clk(clk), .rst(rst),
      .start(accept && iss_div && iss_fx && (iss_pipe[0] == 1'(p))),
      .len(iss_lat), .busy(fx_busy[p])
    );
  end

  logic [CW-1:0] sel_cnt;
  logic [1:0]    sel_pipe;
  logic          cross_fx;
  logic          rdy_now;

  always_comb begin
    sel_cnt  = cnt_arr[lk_src];
    sel_pipe = pipe_arr[lk_src];
    cross_fx = pipe_is_fx(sel_pipe) && pipe_is_fx(lk_pipe)
            && (sel_pipe[0] != lk_pipe[0]);
    rdy_now  = cross_fx ? (sel_cnt == '0) : (sel_cnt <= CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) lk_ready <= 1'b1;
    else     lk_ready <= rdy_now;
  end
endmodule

// File: rtl/opsb_scoreboard_chk.sv
module opsb_scoreboard_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          iss_valid,
  input logic [RW-1:0] iss_dst,
  input logic [1:0]    iss_pipe,
  input logic [2:0]    iss_class,
  input logic [RW-1:0] lk_src,
  input logic [1:0]    lk_pipe,
  input logic          lk_ready,
  input logic [1:0]    fx_busy
);
  logic          simp_q, ld_q;
  logic [RW-1:0] simp_dst, ld_dst;
  logic          same_q, cross_q, ldlk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      simp_q <= 1'b0; ld_q <= 1'b0;
      same_q <= 1'b0; cross_q <= 1'b0; ldlk_q <= 1'b0;
    end else begin
      simp_q  <= iss_valid && iss_pipe == 2'd0 && !fx_busy[0] && iss_class == 3'd0;
      ld_q    <= iss_valid && iss_pipe == 2'd2 && iss_class == 3'd2;
      same_q  <= simp_q && lk_src == simp_dst && lk_pipe == 2'd0;
      cross_q <= simp_q && lk_src == simp_dst && lk_pipe == 2'd1;
      ldlk_q  <= ld_q && lk_src == ld_dst;
    end
    simp_dst <= iss_dst;
    ld_dst   <= iss_dst;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fx_busy == 2'b00 && lk_ready));

  assert_self_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    same_q |-> lk_ready);

  assert_cross_wait_R3: assert property (@(posedge clk) disable iff (rst)
    cross_q |-> !lk_ready);

  assert_load_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    ldlk_q |-> !lk_ready);

  assert_div_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_pipe == 2'd0 && !fx_busy[0] && iss_class[2:1] == 2'b11)
      |=> fx_busy[0]);
endmodule

bind opsb_scoreboard opsb_scoreboard_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_dst(iss_dst),
  .iss_pipe(iss_pipe), .iss_class(iss_class), .lk_src(lk_src),
  .lk_pipe(lk_pipe), .lk_ready(lk_ready), .fx_busy(fx_busy)
);

// File: tb/opsb_scoreboard_test.sv
`timescale 1ns/1ps
module opsb_scoreboard_test;
  localparam int NR = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [RW-1:0] iss_dst = '0, lk_src = '0;
  logic [1:0] iss_pipe = '0, lk_pipe = '0;
  logic [2:0] iss_class = '0;
  logic lk_ready;
  logic [1:0] fx_busy;

  always #2.5 clk = ~clk;

  opsb_scoreboard uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_pipe(iss_pipe), .iss_class(iss_class), .lk_src(lk_src),
    .lk_pipe(lk_pipe), .lk_ready(lk_ready), .fx_busy(fx_busy)
  );

  int total = 0, bad = 0, cyc = 0;
  int ready_at [NR];
  int prod [NR];
  int busy_until [2];
  bit have_prev = 0, exp_prev;
  string tag_prev;

  function automatic int lat_of(input int c);
    case (c)
      0: return 1;  1: return 4;  2: return 2;  3: return 3;
      4: return 5;  5: return 6;  6: return 36; default: return 68;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input int dst, input int pipe, input int cls,
                      input int src, input int lp, input string tag);
    int pen; bit ex; bit acc; string t;
    @(negedge clk);
    for (int p = 0; p < 2; p++) check("R6 fx_busy", int'(fx_busy[p]), int'(cyc < busy_until[p]));
    if (have_prev) check(tag_prev, int'(lk_ready), int'(exp_prev));
    iss_valid = v; iss_dst = RW'(dst); iss_pipe = 2'(pipe); iss_class = 3'(cls);
    lk_src = RW'(src); lk_pipe = 2'(lp);
    pen = (prod[src] < 2 && lp < 2 && prod[src] != lp) ? 1 : 0;
    ex  = (cyc >= ready_at[src] + pen);
    if (tag != "") t = tag;
    else if (pen == 1) t = "R3";
    else if (prod[src] >= 2) t = "R10";
    else t = "R2";
    acc = v && !(pipe < 2 && cyc < busy_until[pipe]) && !(cls >= 6 && pipe >= 2);
    if (acc) begin
      ready_at[dst] = cyc + lat_of(cls);
      prod[dst] = pipe;
      if (cls >= 6) busy_until[pipe] = cyc + lat_of(cls);
    end
    exp_prev = ex; tag_prev = t; have_prev = 1;
    @(posedge clk);
    cyc++;
  endtask

  task automatic idle_look(input int src, input int lp, input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, src, lp, tag);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < NR; i++) begin ready_at[i] = -100; prod[i] = 0; end
    busy_until[0] = 0; busy_until[1] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 lk_ready in reset", int'(lk_ready), 1);
    check("R1 fx_busy in reset", int'(fx_busy), 0);
    rst = 1'b0;
    @(posedge clk);
    // R1: everything ready after reset
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 31, 1, "R1");
    step(0, 0, 0, 0, 7, 3, "R1");
    // R2: self-bypass
    step(1, 1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R2");
    // R3: cross fixed-point pipe
    step(1, 2, 0, 0, 0, 0, "R3");
    idle_look(2, 1, 2, "R3");
    // R5: loads
    step(1, 3, 2, 2, 0, 0, "R5");
    idle_look(3, 0, 2, "R5");
    step(1, 4, 2, 3, 0, 0, "R5");
    idle_look(4, 3, 3, "R5");
    // R4: multiply, FP, vector FP
    step(1, 5, 1, 1, 0, 0, "R4");
    idle_look(5, 1, 5, "R4");
    step(1, 6, 3, 4, 0, 0, "R4");
    idle_look(6, 3, 6, "R4");
    step(1, 14, 3, 5, 0, 0, "R4");
    idle_look(14, 3, 7, "R4");
    // R6 / R7: divide busy and dropped issues
    step(1, 7, 0, 6, 0, 0, "R6");
    idle_look(7, 0, 3, "R6");
    step(1, 8, 0, 4, 0, 0, "R7");
    step(0, 0, 0, 0, 8, 0, "R7");
    step(1, 15, 0, 7, 0, 0, "R7");
    step(0, 0, 0, 0, 15, 1, "R7");
    step(1, 9, 2, 7, 0, 0, "R7");
    step(0, 0, 0, 0, 9, 2, "R7");
    idle_look(7, 0, 34, "R6");
    step(1, 16, 1, 7, 0, 0, "R6");
    idle_look(16, 1, 70, "R6");
    // R8: overwrite shorter and longer
    step(1, 10, 3, 5, 0, 0, "R8");
    step(1, 10, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 10, 0, "R8");
    step(1, 11, 0, 0, 0, 0, "R8");
    step(1, 11, 3, 4, 0, 0, "R8");
    idle_look(11, 3, 6, "R8");
    // R9: same-cycle lookup sees old state
    step(1, 12, 3, 5, 12, 0, "R9");
    step(0, 0, 0, 0, 12, 0, "R9");
    // R10: no adjustment for load/store or vector producers
    step(1, 13, 3, 4, 0, 0, "R10");
    idle_look(13, 1, 6, "R10");
    step(1, 17, 2, 2, 0, 0, "R10");
    idle_look(17, 0, 3, "R10");
    // random traffic on a few hot registers
    for (int n = 0; n < 6000; n++) begin
      int c;
      c = int'($urandom_range(0, 5));
      if ($urandom_range(0, 39) == 0) c = int'($urandom_range(6, 7));
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 3)), c,
           int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), "");
    end
    step(0, 0, 0, 0, 0, 0, "");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule